// File: doc/BRIEF.md
# Trace Message Acceptance and Stability Reporter

This block watches a stream of already-aligned trace multiframes. Each multiframe is either 16 or 64 bytes long. For every one, the block decides whether the message has persisted long enough to become the accepted message. It counts consecutive identical multiframes and accepts a new message once a threshold is reached. The threshold depends on the multiframe length and on whether the 64-byte length is enabled at all.

The accepted message sits in a byte-addressable store that software reads over a simple register port. The block drives three stability indications:

- A one-multiframe match indication.
- A persistent 16-byte stability indication.
- A persistent 64-byte stability indication.

Each indication also has a sticky change latch that software clears by writing 1. Software clears the latches, reads out the message, then reads the latches again. If any latch has come back, the message changed or stability was lost during the readout.

Top module: `trace_accept`

## Requirements
- R1: A new 64-byte message (rx_long=1) is accepted at the end of the 3rd consecutive identical multiframe, which raises stable_64 and stable_1 at that same clock edge.
- R2: A new 16-byte message (rx_long=0) is accepted at the end of the 3rd consecutive identical multiframe when cfg_dual=0, and of the 4th when cfg_dual=1. Acceptance raises stable_16 and stable_1.
- R3: A multiframe that differs from the one before it, in any byte or in length, restarts the identical-multiframe count at 1.
- R4: At each multiframe end, stable_1 becomes 1 if that multiframe equals the accepted message (same length, same bytes) and 0 otherwise. A repeat of the accepted message after a break also needs the R1/R2 count before stable_16 or stable_64 returns.
- R5: stable_16 and stable_64 are never 1 together, and either one being 1 implies stable_1 is 1.
- R6: A 16-byte multiframe made of one repeated byte value is treated as a 16-byte message and reported on stable_16.
- R7: Reading an address from 0 to 63 returns that byte of the accepted message, and all bytes change at the single acceptance edge. The store reads 0 before any acceptance. Writes to addresses 0 to 63 have no effect.
- R8: Address 64 reads the status byte. Its bits are: bit0 stable_1, bit1 stable_16, bit2 stable_64, bit3 latch_1, bit4 latch_16, bit5 latch_64, bit6 accepted length is 64, bit7 a message has been accepted.
- R9: Each latch sets at a multiframe end where a message is accepted or where its own indication falls. Writing to address 64 with bit 3, 4 or 5 set clears the matching latch. A set and a clear in the same cycle leave the latch set.
- R10: The indications and the accepted-length and accepted-flag state change only on the clock edge that takes the last byte of a multiframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dual | input | 1 | 1 when the 64-byte length is enabled alongside the 16-byte length |
| rx_vld | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| rx_last | input | 1 | Marks the last byte of a multiframe |
| rx_long | input | 1 | Multiframe length, 1 for 64 bytes and 0 for 16; sampled with the last byte |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address: 0 to 63 message bytes, 64 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| stable_1 | output | 1 | Latest multiframe equals the accepted message |
| stable_16 | output | 1 | Accepted 16-byte message is persistently received |
| stable_64 | output | 1 | Accepted 64-byte message is persistently received |
| latch_1 | output | 1 | Sticky change latch for stable_1 |
| latch_16 | output | 1 | Sticky change latch for stable_16 |
| latch_64 | output | 1 | Sticky change latch for stable_64 |

## Verification
A software latch clear and a multiframe end that sets the same latch can fall in the same cycle. The bench provokes this by issuing the clearing write during the cycle that carries the last byte of a multiframe. In one case that multiframe breaks stability, so a set and a clear collide. In the other it repeats the accepted message, so nothing sets and the clear acts alone. The status byte read afterwards must show the colliding latches still set and the uncontested latches cleared.

// File: rtl/trace_accept.sv
module trace_accept #(
  parameter int W                  = 8,
  parameter int LONG_LEN           = 64,
  parameter int LONG_PERSIST       = 3,
  parameter int SHORT_PERSIST      = 3,
  parameter int SHORT_PERSIST_DUAL = 4,
  localparam int IW = $clog2(LONG_LEN),
  localparam int AW = IW + 1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_dual,
  input  logic          rx_vld,
  input  logic [W-1:0]  rx_byte,
  input  logic          rx_last,
  input  logic          rx_long,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  output logic          stable_1,
  output logic          stable_16,
  output logic          stable_64,
  output logic          latch_1,
  output logic          latch_16,
  output logic          latch_64
);
  localparam logic [AW-1:0] STAT = AW'(LONG_LEN);

  logic [W-1:0]  prv [LONG_LEN];
  logic [W-1:0]  acc [LONG_LEN];
  logic [IW-1:0] idx;
  logic          dp, da;
  logic          prv_ok, prv_long, acc_ok, acc_long;
  logic [2:0]    cnt;

  wire       mf_end    = rx_vld && rx_last;
  wire       diff_prev = dp || (rx_byte != prv[idx]) || !prv_ok || (prv_long != rx_long);
  wire       diff_acc  = da || (rx_byte != acc[idx]) || !acc_ok || (acc_long != rx_long);
  wire [2:0] cnt_n     = diff_prev ? 3'd1 : ((cnt == 3'd7) ? cnt : cnt + 3'd1);
  wire [2:0] thr16     = cfg_dual ? 3'(SHORT_PERSIST_DUAL) : 3'(SHORT_PERSIST);
  wire [2:0] thr       = rx_long ? 3'(LONG_PERSIST) : thr16;
  wire       take      = diff_acc && (cnt_n >= thr);
  wire       match     = !diff_acc || take;
  wire       s16_n     = match && !rx_long && (cnt_n >= thr16);
  wire       s64_n     = match && rx_long && (cnt_n >= 3'(LONG_PERSIST)) && !s16_n;
  wire       clr       = reg_wr && (reg_addr == STAT);

  logic unused_wdata;
  assign unused_wdata = &{1'b0, reg_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0; dp <= 1'b0; da <= 1'b0;
      prv_ok <= 1'b0; prv_long <= 1'b0; acc_ok <= 1'b0; acc_long <= 1'b0;
      cnt <= '0;
      for (int i = 0; i < LONG_LEN; i++) begin
        prv[i] <= '0;
        acc[i] <= '0;
      end
    end else if (rx_vld) begin
      prv[idx] <= rx_byte;
      idx <= rx_last ? '0 : idx + IW'(1);
      dp  <= rx_last ? 1'b0 : diff_prev;
      da  <= rx_last ? 1'b0 : diff_acc;
      if (rx_last) begin
        prv_ok   <= 1'b1;
        prv_long <= rx_long;
        cnt      <= cnt_n;
        if (take) begin
          acc_ok   <= 1'b1;
          acc_long <= rx_long;
          for (int i = 0; i < LONG_LEN; i++)
            acc[i] <= (IW'(i) == idx) ? rx_byte : prv[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stable_1 <= 1'b0; stable_16 <= 1'b0; stable_64 <= 1'b0;
      latch_1  <= 1'b0; latch_16  <= 1'b0; latch_64  <= 1'b0;
    end else begin
      if (mf_end) begin
        stable_1  <= match;
        stable_16 <= s16_n;
        stable_64 <= s64_n;
      end
      if (mf_end && (take || (stable_1 && !match)))   latch_1 <= 1'b1;
      else if (clr && reg_wdata[3])                    latch_1 <= 1'b0;
      if (mf_end && (take || (stable_16 && !s16_n)))  latch_16 <= 1'b1;
      else if (clr && reg_wdata[4])                    latch_16 <= 1'b0;
      if (mf_end && (take || (stable_64 && !s64_n)))  latch_64 <= 1'b1;
      else if (clr && reg_wdata[5])                    latch_64 <= 1'b0;
    end
  end

  wire [7:0] status = {acc_ok, acc_long, latch_64, latch_16, latch_1,
                       stable_64, stable_16, stable_1};

  assign reg_rdata = (reg_addr == STAT)     ? W'(status) :
                     (reg_addr < STAT)      ? acc[reg_addr[IW-1:0]] : '0;

  // R5
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stable_16 && stable_64));

  // R5
  imply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stable_16 || stable_64) |-> stable_1);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mf_end) |-> $stable({stable_1, stable_16, stable_64, acc_ok, acc_long}));

  // R9
  fall_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stable_1) |-> latch_1);

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && reg_wdata[3] && !mf_end) |=> !latch_1);
endmodule

// File: tb/trace_accept_bench.sv
module trace_accept_bench;
  logic       clk = 0, rst_n = 0, cfg_dual = 0;
  logic       rx_vld = 0, rx_last = 0, rx_long = 0, reg_wr = 0;
  logic [7:0] rx_byte = 0, reg_wdata = 0, reg_rdata;
  logic [6:0] reg_addr = 0;
  logic       stable_1, stable_16, stable_64, latch_1, latch_16, latch_64;
  int         total = 0, bad = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  trace_accept u_trace_accept (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic chk_stat(input string tag, input logic [7:0] exp);
    logic [7:0] d;
    rd(7'd64, d);
    chk(tag, d, exp);
  endtask

  task automatic chk_byte(input string tag, input logic [6:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic do_reset(input logic dual);
    @(negedge clk);
    rst_n = 0; cfg_dual = dual;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic send(input logic lng, input logic [7:0] seed, input logic [7:0] step,
                      input logic clr_last);
    int n = lng ? 64 : 16;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_vld = 1; rx_byte = seed + 8'(i) * step; rx_last = (i == n - 1); rx_long = lng;
      if (clr_last && i == n - 1) begin
        reg_wr = 1; reg_addr = 7'd64; reg_wdata = 8'h38;
      end
    end
    @(negedge clk);
    rx_vld = 0; rx_last = 0; reg_wr = 0;
  endtask

  task automatic t_reset;
    do_reset(0);
    chk_stat("R8 reset status", 8'h00);
    chk_byte("R7 reset store", 7'd0, 8'h00);
    chk("R5 reset ports", {2'b0, latch_64, latch_16, latch_1, stable_64, stable_16, stable_1}, 8'h00);
  endtask

  task automatic t_short_single;
    do_reset(0);
    send(0, 8'h10, 8'h01, 0); send(0, 8'h10, 8'h01, 0);
    chk_stat("R2 short two mf", 8'h00);
    send(0, 8'h10, 8'h01, 0);
    chk_stat("R2 short accept at 3", 8'hBB);
    chk("R2 stable_16 port", {7'b0, stable_16}, 8'h01);
    chk_byte("R7 byte5", 7'd5, 8'h15);
    chk_byte("R7 byte15", 7'd15, 8'h1F);
    wr(7'd5, 8'hEE);
    chk_byte("R7 write ignored", 7'd5, 8'h15);
    wr(7'd64, 8'h38);
    chk_stat("R9 latch clear", 8'h83);
  endtask

  task automatic t_short_dual;
    do_reset(1);
    for (int k = 0; k < 3; k++) send(0, 8'h10, 8'h01, 0);
    chk_stat("R2 dual three mf", 8'h00);
    send(0, 8'h10, 8'h01, 0);
    chk_stat("R2 dual accept at 4", 8'hBB);
  endtask

  task automatic t_long;
    do_reset(1);
    send(1, 8'h40, 8'h03, 0); send(1, 8'h40, 8'h03, 0);
    chk_stat("R1 long two mf", 8'h00);
    send(1, 8'h40, 8'h03, 0);
    chk_stat("R1 long accept at 3", 8'hFD);
    chk("R1 stable_64 port", {7'b0, stable_64}, 8'h01);
    chk_byte("R7 byte63", 7'd63, 8'hFD);
  endtask

  task automatic t_repeat;
    do_reset(0);
    for (int k = 0; k < 3; k++) send(0, 8'h10, 8'h01, 0);
    wr(7'd64, 8'h38);
    send(0, 8'h80, 8'h01, 0);
    chk_stat("R4 other mf drops stable", 8'h98);
    chk_byte("R7 store kept", 7'd5, 8'h15);
    wr(7'd64, 8'h38);
    send(0, 8'h10, 8'h01, 0);
    chk_stat("R4 repeat one mf stable_1", 8'h81);
    send(0, 8'h10, 8'h01, 0);
    chk_stat("R4 repeat two mf", 8'h81);
    send(0, 8'h10, 8'h01, 0);
    chk_stat("R4 repeat three mf stable_16", 8'h83);
  endtask

  task automatic t_restart;
    do_reset(0);
    send(0, 8'h10, 8'h01, 0); send(0, 8'h10, 8'h01, 0);
    send(0, 8'h80, 8'h01, 0); send(0, 8'h80, 8'h01, 0);
    chk_stat("R3 count restarted", 8'h00);
    send(0, 8'h80, 8'h01, 0);
    chk_stat("R3 accept after restart", 8'hBB);
    chk_byte("R3 new byte0", 7'd0, 8'h80);
  endtask

  task automatic t_single_byte;
    do_reset(0);
    for (int k = 0; k < 3; k++) send(0, 8'h5A, 8'h00, 0);
    chk_stat("R6 single byte stable_16", 8'hBB);
    chk_byte("R6 byte9", 7'd9, 8'h5A);
  endtask

  task automatic t_collide;
    do_reset(0);
    for (int k = 0; k < 3; k++) send(0, 8'h10, 8'h01, 0);
    wr(7'd64, 8'h38);
    send(0, 8'h80, 8'h01, 1);
    chk_stat("R9 set wins over clear", 8'h98);
    send(0, 8'h10, 8'h01, 1);
    chk_stat("R9 clear with no event", 8'h81);
  endtask

  task automatic t_format;
    do_reset(0);
    for (int k = 0; k < 3; k++) send(0, 8'h10, 8'h01, 0);
    wr(7'd64, 8'h38);
    send(1, 8'h10, 8'h01, 0);
    chk_stat("R3 length change differs", 8'h98);
    send(1, 8'h10, 8'h01, 0); send(1, 8'h10, 8'h01, 0);
    chk_stat("R1 long after short", 8'hFD);
    chk_byte("R7 byte40", 7'd40, 8'h38);
  endtask

  initial begin
    t_reset();
    t_short_single();
    t_short_dual();
    t_long();
    t_repeat();
    t_restart();
    t_single_byte();
    t_collide();
    t_format();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule